// File: doc/BRIEF.md
# Level-Triggered DMA Request Sequencer

This block runs one DMA channel that is started by an active-low, level-sensitive request pin. After software enables the channel, the block samples the pin on every rising clock edge while it is free to take a request. When it sees a low level, it holds that request internally. It then waits for the processor to release the bus, which arrives as a one-cycle bus-free pulse. At that pulse it drops the held request and begins a transfer.

Each transfer has three cycles. An activation cycle comes first. A read cycle from the source address follows. A write cycle then puts the captured word at the destination address. While a transfer is under way, new requests are not taken. Sampling resumes once the write cycle has ended. A counter counts the transfers. When it runs out, the channel turns itself off and raises a done flag.

Software sets up the channel through a small register-write port. It writes the source address, the destination address, the transfer count, and a control word that holds the enable and level-mode bits.

Top module: `dreq_seq`

## Requirements
- R1: After reset, `bus_own`, `bus_rd`, `bus_wr` and `done` are 0, and `bus_addr` is 0.
- R2: The register port uses `cfg_sel` 0 for the source address, 1 for the destination address, 2 for the count (low `CNT_W` bits of `cfg_wdata`), and 3 for control. In the control word, bit 0 is enable and bit 1 is level mode. Pin sampling begins on the first rising edge after the control write that sets enable; a low level present only during that write's own edge is not taken.
- R3: Once a low level has been sampled, the request stays held even if the pin returns high. Nothing starts until a `bus_free` pulse arrives, and the first such pulse starts the transfer.
- R4: A transfer is one activation cycle (`bus_own`=1, no strobes), then one read cycle (`bus_rd`=1, `bus_addr`=source), then one write cycle (`bus_wr`=1, `bus_addr`=destination, `bus_wdata`=the word read). The read cycle starts no sooner than two cycles after the request was sampled.
- R5: The pin is ignored from activation until the write cycle ends. Sampling reopens on the edge after the write cycle.
- R6: The source address advances by `DATA_W/8` after each read, and the destination address advances by the same amount after each write. Both wrap modulo 2^`ADDR_W`.
- R7: The count drops by one per write. When it reaches zero, enable clears, `done` rises, and further requests start nothing. Enabling with a count of zero sets `done` at once and starts nothing. Enabling with a nonzero count clears `done`.
- R8: When enable is 1 and level mode is 0, the pin is ignored.
- R9: Writes to the source, destination or count registers are ignored while the channel is enabled or a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | ADDR_W | Register write data |
| req_n | input | 1 | Active-low level request pin |
| bus_free | input | 1 | One-cycle pulse: processor has released the bus |
| bus_rdata | input | DATA_W | Read data returned during the read cycle |
| bus_addr | output | ADDR_W | Bus address (0 when not owning the bus) |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DATA_W | Write data |
| bus_own | output | 1 | Sequencer is driving the bus |
| done | output | 1 | Programmed count exhausted |

## Verification
The assertions assume that `bus_free` is a single-cycle pulse, that `bus_rdata` is valid within the read cycle, and that software does not re-enable the channel in the very cycle a transfer ends. The bench drives every input just after a clock edge. It raises `bus_free` for exactly one cycle at a time and returns read data as a fixed function of `bus_addr`, so the expected write data is known. Its enable writes are issued only while the sequencer is idle.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACT   = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } xfer_state_e;

    typedef enum logic [1:0] {
        CFG_SRC  = 2'd0,
        CFG_DST  = 2'd1,
        CFG_CNT  = 2'd2,
        CFG_CTRL = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic level;
        logic enable;
    } ctrl_bits_t;

    function automatic int unsigned step_bytes(int unsigned dw);
        return (dw < 8) ? 1 : dw / 8;
    endfunction

endpackage

// File: rtl/dreq_accept.sv
module dreq_accept (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic open_i,
    input  logic req_n,
    input  logic activate_i,
    output logic held_o
);
    logic held_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            held_q <= 1'b0;
        end else if (activate_i) begin
            held_q <= 1'b0;
        end else if (open_i && !req_n) begin
            held_q <= 1'b1;
        end
    end

    assign held_o = held_q;

    // R5
    held_only_when_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(held_q) |-> $past(open_i && !req_n));

    // R3
    held_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (held_q && en_i && !activate_i) |=> held_q);

endmodule

// File: rtl/dreq_xfer_ctrl.sv
module dreq_xfer_ctrl
    import dreq_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  cfg_sel_e      cfg_sel,
    input  ctrl_bits_t    ctrl_wdata,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          held_i,
    input  logic          bus_free_i,
    output xfer_state_e   state_o,
    output logic          en_o,
    output logic          open_o,
    output logic          activate_o,
    output logic          lock_o,
    output logic          done_o
);
    xfer_state_e   state_q;
    logic          en_q;
    logic          level_q;
    logic          done_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_after;
    logic          activate;

    assign activate  = (state_q == ST_IDLE) && en_q && held_i && bus_free_i;
    assign cnt_after = (state_q == ST_WRITE) ? cnt_q - 1'b1 : cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            en_q    <= 1'b0;
            level_q <= 1'b0;
            done_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE:  if (activate) state_q <= ST_ACT;
                ST_ACT:   state_q <= ST_READ;
                ST_READ:  state_q <= ST_WRITE;
                default:  state_q <= ST_IDLE;
            endcase

            if (state_q == ST_WRITE) begin
                cnt_q <= cnt_after;
                if (cnt_q == {{(CW-1){1'b0}}, 1'b1}) begin
                    en_q   <= 1'b0;
                    done_q <= 1'b1;
                end
            end

            if (cfg_we) begin
                case (cfg_sel)
                    CFG_CNT: if (!lock_o) cnt_q <= cnt_wdata;
                    CFG_CTRL: begin
                        level_q <= ctrl_wdata.level;
                        if (ctrl_wdata.enable) begin
                            if (cnt_after == '0) begin
                                en_q   <= 1'b0;
                                done_q <= 1'b1;
                            end else begin
                                en_q   <= 1'b1;
                                done_q <= 1'b0;
                            end
                        end else begin
                            en_q <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign state_o    = state_q;
    assign en_o       = en_q;
    assign open_o     = en_q && level_q && (state_q == ST_IDLE) && !held_i;
    assign activate_o = activate;
    assign lock_o     = en_q || (state_q != ST_IDLE);
    assign done_o     = done_q;

    // R4
    read_after_act_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READ) |-> ($past(state_q) == ST_ACT));

    // R3
    act_needs_free_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACT) |-> $past(held_i && bus_free_i));

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WRITE) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7
    done_disables_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> !en_q);

endmodule

// File: rtl/dreq_addr_gen.sv
module dreq_addr_gen
    import dreq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  cfg_sel_e      cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          lock_i,
    input  logic          step_src_i,
    input  logic          step_dst_i,
    input  logic [DW-1:0] rdata_i,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [DW-1:0] wdata_o
);
    localparam logic [AW-1:0] STEP = AW'(step_bytes(DW));

    logic [AW-1:0] src_q, dst_q;
    logic [DW-1:0] buf_q;
    logic          load_ok;

    assign load_ok = cfg_we && !lock_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            dst_q <= '0;
            buf_q <= '0;
        end else begin
            if (step_src_i) begin
                src_q <= src_q + STEP;
                buf_q <= rdata_i;
            end else if (load_ok && cfg_sel == CFG_SRC) begin
                src_q <= cfg_wdata;
            end
            if (step_dst_i) begin
                dst_q <= dst_q + STEP;
            end else if (load_ok && cfg_sel == CFG_DST) begin
                dst_q <= cfg_wdata;
            end
        end
    end

    assign src_o   = src_q;
    assign dst_o   = dst_q;
    assign wdata_o = buf_q;

    // R6
    src_step_chk: assert property (@(posedge clk) disable iff (rst)
        step_src_i |=> (src_q == $past(src_q) + STEP));

    // R6
    dst_step_chk: assert property (@(posedge clk) disable iff (rst)
        step_dst_i |=> (dst_q == $past(dst_q) + STEP));

    // R9
    src_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_i && !step_src_i) |=> $stable(src_q));

endmodule

// File: rtl/dreq_seq.sv
module dreq_seq
    import dreq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          req_n,
    input  logic          bus_free,
    input  logic [DW-1:0] bus_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_own,
    output logic          done
);
    xfer_state_e   state;
    cfg_sel_e      sel;
    ctrl_bits_t    ctrl_w;
    logic          en, open, activate, lock, held;
    logic [AW-1:0] src, dst;

    assign sel    = cfg_sel_e'(cfg_sel);
    assign ctrl_w = ctrl_bits_t'(cfg_wdata[1:0]);

    dreq_accept u_accept (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en),
        .open_i     (open),
        .req_n      (req_n),
        .activate_i (activate),
        .held_o     (held)
    );

    dreq_xfer_ctrl #(.CW(CW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (sel),
        .ctrl_wdata (ctrl_w),
        .cnt_wdata  (cfg_wdata[CW-1:0]),
        .held_i     (held),
        .bus_free_i (bus_free),
        .state_o    (state),
        .en_o       (en),
        .open_o     (open),
        .activate_o (activate),
        .lock_o     (lock),
        .done_o     (done)
    );

    dreq_addr_gen #(.AW(AW), .DW(DW)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_sel    (sel),
        .cfg_wdata  (cfg_wdata),
        .lock_i     (lock),
        .step_src_i (state == ST_READ),
        .step_dst_i (state == ST_WRITE),
        .rdata_i    (bus_rdata),
        .src_o      (src),
        .dst_o      (dst),
        .wdata_o    (bus_wdata)
    );

    always_comb begin
        case (state)
            ST_READ:  bus_addr = src;
            ST_WRITE: bus_addr = dst;
            default:  bus_addr = '0;
        endcase
    end

    assign bus_rd  = (state == ST_READ);
    assign bus_wr  = (state == ST_WRITE);
    assign bus_own = (state != ST_IDLE);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_rd, bus_wr}));

    // R4
    read_owned_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rd) |-> $past(bus_own));

    // R4
    write_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> $past(bus_rd));

endmodule

// File: tb/test_dreq_seq.sv
module test_dreq_seq;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam logic [15:0] KEY = 16'h5A3C;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [1:0]    cfg_sel;
    logic [AW-1:0] cfg_wdata;
    logic          req_n;
    logic          bus_free;
    logic [DW-1:0] bus_rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_rd, bus_wr, bus_own, done;
    logic [DW-1:0] bus_wdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign bus_rdata = bus_addr ^ KEY;

    dreq_seq i_dreq_seq (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_n(req_n), .bus_free(bus_free),
        .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_own(bus_own), .done(done)
    );

    // vector: src, dst, count
    localparam int NV = 4;
    localparam logic [39:0] VEC [NV] = '{
        {16'h1000, 16'h2000, 8'd3},
        {16'hFFFC, 16'h0100, 8'd3},
        {16'h0000, 16'hFFFE, 8'd2},
        {16'h4242, 16'h8000, 8'd1}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] data);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic quiet(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            bus_free = 1'b1;
            tick();
            bus_free = 1'b0;
            check(req, "bus_own stays low", bus_own, 1'b0);
        end
    endtask

    // precondition: request already held, idle, just after an edge
    task automatic do_xfer(input string req, input logic [AW-1:0] s,
                           input logic [AW-1:0] d, input bit busy_req);
        bus_free = 1'b1;
        tick();
        bus_free = 1'b0;
        if (busy_req) req_n = 1'b0;
        check(req, "act own", bus_own, 1'b1);
        check(req, "act strobes", {bus_rd, bus_wr}, 2'b00);
        tick();
        check(req, "read strobe", {bus_rd, bus_wr}, 2'b10);
        check(req, "read addr (R6)", bus_addr, s);
        tick();
        check(req, "write strobe", {bus_rd, bus_wr}, 2'b01);
        check(req, "write addr (R6)", bus_addr, d);
        check(req, "write data (R4)", bus_wdata, s ^ KEY);
        if (busy_req) req_n = 1'b1;
        tick();
        check(req, "released", bus_own, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        req_n = 1'b1; bus_free = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1
        check("R1", "bus_own", bus_own, 1'b0);
        check("R1", "strobes", {bus_rd, bus_wr}, 2'b00);
        check("R1", "done", done, 1'b0);
        check("R1", "bus_addr", bus_addr, '0);

        // vector table: R2, R4, R6, R7
        for (int v = 0; v < NV; v++) begin
            logic [15:0] s, d;
            logic [7:0]  n;
            {s, d, n} = VEC[v];
            cfg(2'd0, s);
            cfg(2'd1, d);
            cfg(2'd2, {8'd0, n});
            req_n = 1'b0;
            cfg(2'd3, 16'd3);
            check("R7", "done cleared on enable", done, 1'b0);
            for (int k = 0; k < int'(n); k++) begin
                tick();
                do_xfer("R2", s + 16'(2 * k), d + 16'(2 * k), 1'b0);
            end
            check("R7", "done after count", done, 1'b1);
            quiet("R7", 3);
            req_n = 1'b1;
        end

        // R7: enable with zero count
        cfg(2'd2, 16'd1);
        cfg(2'd3, 16'd3);
        check("R7", "done clear", done, 1'b0);
        cfg(2'd3, 16'd0);
        cfg(2'd2, 16'd0);
        req_n = 1'b0;
        cfg(2'd3, 16'd3);
        check("R7", "zero count done", done, 1'b1);
        quiet("R7", 3);
        req_n = 1'b1;

        // R3 and R5
        cfg(2'd0, 16'h0100);
        cfg(2'd1, 16'h0200);
        cfg(2'd2, 16'd2);
        cfg(2'd3, 16'd3);
        quiet("R3", 2);
        req_n = 1'b0;
        tick();
        req_n = 1'b1;
        repeat (3) tick();
        check("R3", "no start without bus_free", bus_own, 1'b0);
        do_xfer("R3", 16'h0100, 16'h0200, 1'b1);
        quiet("R5", 3);
        req_n = 1'b0;
        tick();
        req_n = 1'b1;
        do_xfer("R5", 16'h0102, 16'h0202, 1'b0);
        check("R5", "done", done, 1'b1);

        // R8: level mode off
        cfg(2'd2, 16'd2);
        req_n = 1'b0;
        cfg(2'd3, 16'd1);
        quiet("R8", 4);
        req_n = 1'b1;
        cfg(2'd3, 16'd0);

        // R9: writes while enabled ignored
        cfg(2'd0, 16'h3000);
        cfg(2'd1, 16'h5000);
        cfg(2'd2, 16'd1);
        cfg(2'd3, 16'd3);
        cfg(2'd0, 16'h7777);
        cfg(2'd1, 16'h6666);
        cfg(2'd2, 16'd9);
        req_n = 1'b0;
        tick();
        req_n = 1'b1;
        do_xfer("R9", 16'h3000, 16'h5000, 1'b0);
        check("R9", "count write ignored", done, 1'b1);

        // R2: low only during the enabling write is not taken
        cfg(2'd0, 16'h0A00);
        cfg(2'd1, 16'h0B00);
        cfg(2'd2, 16'd1);
        req_n = 1'b0;
        cfg(2'd3, 16'd3);
        req_n = 1'b1;
        quiet("R2", 3);
        req_n = 1'b0;
        tick();
        req_n = 1'b1;
        do_xfer("R2", 16'h0A00, 16'h0B00, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule